// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Select Word

This block gathers 64 level-sensitive interrupt inputs and drives one interrupt line toward the processor. Every source has its own 32-bit configuration word. A 7-bit route field in that word holds the routing choice. One bit of the field sends the source to the normal interrupt line. A second bit records a fast-line route, which is stored and read back but drives no output here. The other five bits are plain storage.

A read-only select word tells software, in a single read, whether any routed source is active and which one it is. When several sources are active, the lowest-numbered one is reported. Software masks a source by writing zero into the route field and unmasks it by writing the normal-route value. The source inputs are asynchronous, so they pass through a synchronizer before they reach the pending logic.

Top module: `irq_route_ctrl`

## Requirements
- R1: Source n (0 to 63) has a configuration word at byte offset 4*n. A write stores data bits 6:0. A read returns those seven bits, and bits 31:7 read as zero.
- R2: After reset, every configuration word reads zero, the select word reads zero and `irq_o` is low.
- R3: A source counts as pending only when its synchronized input is high and bit 5 (normal route, value 0x20) of its configuration word is set. Bit 6 (fast route, 0x40) and bits 4:0 do not make a source pending.
- R4: The select word sits at offset 0x104. Bit 6 is the pending flag and bits 5:0 hold the number of the chosen source. When nothing is pending, the whole word reads 0.
- R5: When several sources are pending, the select word reports the lowest-numbered one.
- R6: The inputs are level-sensitive. A source stays pending while its input is high and bit 5 is set. It stops being pending as soon as the input falls or bit 5 is cleared.
- R7: `irq_o` is the pending flag delayed by one register. It rises one clock after the select word shows a pending source and falls one clock after the last pending source goes away.
- R8: A change on a source input reaches the select word after exactly two rising clock edges.
- R9: Writes to the select word offset (0x104), to unused offsets (0x100, and 0x108 and above) and to offsets not aligned to a word leave every configuration word unchanged.
- R10: Reads from unused offsets (0x100, and 0x108 and above) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 64 | Level-sensitive interrupt inputs, asynchronous to clk |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from registered state |
| irq_o | output | 1 | Normal interrupt line toward the processor |

## Verification
The selection logic is tried with three kinds of input. A walking single source across all 64 positions shows that each number is encoded correctly and that each line is wired to its own input. Descending suffix patterns with every source enabled show that the lowest active number wins at every position. Pseudo-random enable and input vectors, compared against a bench model, show that the enable and input masks are ANDed correctly. Separate patterns set only the fast-route bit or only the spare bits, disable a source while its input stays high, and step the clock one edge at a time. These tell apart a wrong route bit, a missing level-sensitive drop, and a synchronizer or output register with the wrong number of stages.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int CFG_W        = 7;
  localparam int NRM_BIT      = 5;
  localparam int FST_BIT      = 6;
  localparam int SEL_PEND_BIT = 6;
  localparam int SEL_OFFSET   = 'h104;

  typedef struct packed {
    logic       fast;
    logic       normal;
    logic [4:0] spare;
  } route_cfg_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] chain_d;
    if (s == 0) begin : g_first
      assign chain_d = d_i;
    end else begin : g_rest
      assign chain_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CFG_W-1:0]         wdata_i,
  output logic                     hit_o,
  output logic [CFG_W-1:0]         rd_o,
  output logic [NUM_SRC*CFG_W-1:0] cfg_flat_o,
  output logic [NUM_SRC-1:0]       nrm_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign hit_o    = aligned && (int'(word_idx) < NUM_SRC);

  route_cfg_t cfg_q [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_word
    logic       we;
    route_cfg_t cfg_d;

    assign we = wr_i && hit_o && (int'(word_idx) == i);

    always_comb begin
      cfg_d = cfg_q[i];
      if (we) cfg_d = route_cfg_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q[i] <= '0;
      else if (we) cfg_q[i] <= cfg_d;
    end

    assign cfg_flat_o[i*CFG_W +: CFG_W] = cfg_q[i];
    assign nrm_o[i] = cfg_q[i].normal;
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(word_idx) == i) rd_o = cfg_q[i];
    end
  end
endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic                     rst_n_s;
  logic [NUM_SRC-1:0]       src_s;
  logic [NUM_SRC-1:0]       nrm_en;
  logic [NUM_SRC*CFG_W-1:0] cfg_flat;
  logic                     cfg_hit;
  logic [CFG_W-1:0]         cfg_rd;
  logic                     pend_any;
  logic [IDX_W-1:0]         sel_idx;
  logic                     sel_hit;
  logic                     irq_d;
  logic                     irq_q;
  logic                     unused_wdata;

  assign unused_wdata = ^bus_wdata[31:CFG_W];

  irq_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  irq_in_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  irq_cfg_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata[CFG_W-1:0]),
    .hit_o      (cfg_hit),
    .rd_o       (cfg_rd),
    .cfg_flat_o (cfg_flat),
    .nrm_o      (nrm_en)
  );

  irq_pick_low #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i (src_s & nrm_en),
    .any_o (pend_any),
    .idx_o (sel_idx)
  );

  assign sel_hit = (int'(bus_addr) == SEL_OFFSET);

  always_comb begin
    bus_rdata = '0;
    if (sel_hit) begin
      bus_rdata[SEL_PEND_BIT] = pend_any;
      bus_rdata[IDX_W-1:0]    = sel_idx;
    end else if (cfg_hit) begin
      bus_rdata[CFG_W-1:0] = cfg_rd;
    end
  end

  assign irq_d = pend_any;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC-1:0]       src_s,
  input logic [NUM_SRC*CFG_W-1:0] cfg_flat,
  input logic                     pend_any,
  input logic [IDX_W-1:0]         sel_idx,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     irq_o
);
  logic [NUM_SRC-1:0] nrm;
  logic [NUM_SRC-1:0] below;
  logic [NUM_SRC-1:0] live;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) nrm[i] = cfg_flat[i*CFG_W + NRM_BIT];
    below = (NUM_SRC'(1) << sel_idx) - NUM_SRC'(1);
    live  = src_s & nrm;
  end

  p_pick_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> (src_s[sel_idx] && nrm[sel_idx]));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |-> (live == '0 && sel_idx == '0));

  p_pick_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> ((live & below) == '0));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(pend_any)));

  p_sel_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == SEL_OFFSET) |=> $stable(cfg_flat));
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .src_s    (src_s),
  .cfg_flat (cfg_flat),
  .pend_any (pend_any),
  .sel_idx  (sel_idx),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .irq_o    (irq_o)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  localparam int CLK_P = 10;
  localparam int N     = 64;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [N-1:0] src;
  logic [11:0] addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [6:0]  model [N];
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  irq_route_ctrl uut (
    .clk (clk), .arst_n (arst_n), .src_i (src), .bus_addr (addr),
    .bus_wr (wr), .bus_wdata (wdata), .bus_rdata (rdata), .irq_o (irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_word(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    if (a[1:0] == 2'b00 && int'(a) < 4*N) model[a[11:2]] = d[6:0];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_word(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] exp_sel(logic [N-1:0] s);
    for (int i = 0; i < N; i++)
      if (s[i] && model[i][5]) return 32'h40 | 32'(i);
    return 32'h0;
  endfunction

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) model[i] = '0;
    arst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; wdata = '0;
    tick(3);
    arst_n = 1'b1;
    tick(3);

    // R2: reset state
    rd_word(12'h104, d); chk("R2 select", d, 32'h0);
    chk("R2 irq", 32'(irq), 32'h0);
    for (int i = 0; i < N; i++) begin
      rd_word(12'(4*i), d); chk("R2 cfg", d, 32'h0);
    end

    // R1: readback keeps bits 6:0 only
    for (int i = 0; i < N; i++) wr_word(12'(4*i), 32'hABCDE080 | 32'((i*37 + 5) & 32'h7F));
    for (int i = 0; i < N; i++) begin
      rd_word(12'(4*i), d); chk("R1 readback", d, 32'((i*37 + 5) & 32'h7F));
    end
    for (int i = 0; i < N; i++) wr_word(12'(4*i), 32'h0);

    // R6/R7: walking single source, rise and fall
    for (int i = 0; i < N; i++) begin
      wr_word(12'(4*i), 32'h20);
      src = N'(1) << i;
      tick(2); rd_word(12'h104, d); chk("R6 single select", d, 32'h40 | 32'(i));
      tick(1); chk("R7 irq rise", 32'(irq), 32'h1);
      src = '0;
      tick(2); rd_word(12'h104, d); chk("R6 single drop", d, 32'h0);
      tick(1); chk("R7 irq fall", 32'(irq), 32'h0);
      wr_word(12'(4*i), 32'h0);
    end

    // R8/R7: edge-by-edge latency
    wr_word(12'h0C, 32'h20);
    src = N'(1) << 3;
    tick(1); rd_word(12'h104, d); chk("R8 one edge", d, 32'h0);
    tick(1); rd_word(12'h104, d); chk("R8 two edges", d, 32'h43);
    chk("R7 irq not yet", 32'(irq), 32'h0);
    tick(1); chk("R7 irq after", 32'(irq), 32'h1);
    src = '0; tick(3);
    wr_word(12'h0C, 32'h0);

    // R6: disable while input stays high
    wr_word(12'h28, 32'h20);
    src = N'(1) << 10;
    tick(3); rd_word(12'h104, d); chk("R6 enabled", d, 32'h4A);
    wr_word(12'h28, 32'h0);
    rd_word(12'h104, d); chk("R6 disabled", d, 32'h0);
    tick(1); chk("R6 irq off", 32'(irq), 32'h0);
    src = '0;

    // R3: fast bit and spare bits do not make a source pending
    src = N'(1) << 7;
    wr_word(12'h1C, 32'h40); tick(3);
    rd_word(12'h104, d); chk("R3 fast only", d, 32'h0);
    chk("R3 fast irq", 32'(irq), 32'h0);
    wr_word(12'h1C, 32'h1F); tick(3);
    rd_word(12'h104, d); chk("R3 spare only", d, 32'h0);
    wr_word(12'h1C, 32'h7F); tick(1);
    rd_word(12'h104, d); chk("R3 full field", d, 32'h47);
    src = '0;
    wr_word(12'h1C, 32'h0);

    // R5: all enabled, descending suffix patterns
    for (int i = 0; i < N; i++) wr_word(12'(4*i), 32'h20);
    for (int i = 0; i < N; i++) begin
      src = ~((N'(1) << i) - N'(1));
      tick(2); rd_word(12'h104, d); chk("R5 lowest wins", d, 32'h40 | 32'(i));
    end

    // R4/R5: pseudo-random enables and inputs against the model
    for (int e = 0; e < 12; e++) begin
      logic [63:0] en;
      en = next_rand();
      for (int i = 0; i < N; i++) wr_word(12'(4*i), en[i] ? 32'h20 : 32'h40);
      for (int p = 0; p < 10; p++) begin
        src = next_rand() & next_rand();
        if (p == 9) src = '0;
        tick(2); rd_word(12'h104, d); chk("R4 random select", d, exp_sel(src));
        tick(1); chk("R7 random irq", 32'(irq), 32'(exp_sel(src) != 0));
      end
    end

    // R9/R10: ignored writes and unused reads
    src = N'(1) << 20;
    wr_word(12'h104, 32'hFFFFFFFF);
    wr_word(12'h100, 32'h7F);
    wr_word(12'h108, 32'h7F);
    wr_word(12'h002, 32'h7F);
    for (int i = 0; i < N; i++) begin
      rd_word(12'(4*i), d); chk("R9 cfg untouched", d, 32'(model[i]));
    end
    tick(2); rd_word(12'h104, d); chk("R9 select", d, exp_sel(src));
    rd_word(12'h100, d); chk("R10 unused 0x100", d, 32'h0);
    rd_word(12'h108, d); chk("R10 unused 0x108", d, 32'h0);
    rd_word(12'hFFC, d); chk("R10 unused 0xFFC", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule